// File: doc/BRIEF.md
# Early/Late Tracking Code Selector

This block sits between the code generator and the accumulators of one correlator channel. Each cycle it takes the current early, prompt and late code chips, where logic 0 stands for +1 and logic 1 for −1. It converts them into signed 2-bit values for the code mixers and forms the tracking-arm code. A 2-bit select sets the tracking arm to the early code, the late code, a dithered code or a halved early-minus-late difference.

In dither mode the tracking arm uses early code for a run of code periods and then late code for an equal run, switching back and forth without end. A strobe that marks each 1 ms code period boundary drives the count. The current dither half is visible as a status bit. A test control forces the prompt, early and late outputs to +1, so the mixers pass their inputs unchanged, and forces the early-minus-late result to 0. Every output is registered, one clock after its inputs.

Top module: `trk_code_sel`

## Requirements
- R1: Each of prompt_o, early_o and late_o shows its chip one cycle later, with chip 0 as +1 (2'b01) and chip 1 as −1 (2'b11), while code_off_i is low.
- R2: While code_off_i is high, prompt_o, early_o and late_o are +1 (2'b01) one cycle later, whatever the chips.
- R3: Select 2'b00 makes track_o the mapped early chip.
- R4: Select 2'b01 makes track_o the mapped late chip.
- R5: Select 2'b11 makes track_o 0 (2'b00) when the early and late chips are equal. Otherwise it takes the sign of the early chip (+1 or −1).
- R6: With code_off_i high, track_o is 0 in select 2'b11 and +1 in every other select.
- R7: Select 2'b10 makes track_o the mapped early chip while dither_late_o is 0 and the mapped late chip while it is 1.
- R8: The dither phase dither_late_o inverts on every 20th period strobe (parameter DITHER_LEN) and holds between those strobes.
- R9: While rst_ni is low, all four value outputs are 0 (2'b00) and dither_late_o is 0, so the early half comes first.
- R10: Changing the select neither clears nor pauses the dither strobe count.
- R11: track_o never carries 2'b10, and it is 0 only when the select was 2'b11.
- R12: Each value output reflects the inputs present at the previous rising clock edge and does not follow input changes between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| early_i | input | 1 | Early code chip (0 = +1, 1 = −1) |
| prompt_i | input | 1 | Prompt code chip |
| late_i | input | 1 | Late code chip |
| trk_sel_i | input | 2 | Tracking select: 00 early, 01 late, 10 dither, 11 halved early-minus-late |
| code_off_i | input | 1 | Test control forcing the code outputs to their neutral values |
| epoch_i | input | 1 | One-cycle strobe at each code period boundary |
| prompt_o | output | 2 | Prompt value, signed 2-bit |
| early_o | output | 2 | Early value, signed 2-bit |
| late_o | output | 2 | Late value, signed 2-bit |
| track_o | output | 2 | Tracking-arm value, signed 2-bit |
| dither_late_o | output | 1 | Dither phase: 0 early half, 1 late half |

## Verification
The bench drives the difference mode with all four early/late chip pairs. A design that forgot the halving would give 2'b10 for unequal chips, and one that took the late chip's sign would get both unequal cases backwards. It counts exactly 19 strobes and checks that the phase has not moved, then sends the 20th and checks that it has. An off-by-one counter fails one of those two checks. It then changes the select partway through a dither run and confirms the phase still flips after 20 strobes in total, which catches a counter cleared on a select change. It also checks that the code-off test forces 0 only in difference mode and +1 in the others, and that an input change between edges does not show up before the next edge.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef logic [1:0] sval_t;

  localparam sval_t SV_P1 = 2'b01;
  localparam sval_t SV_Z  = 2'b00;
  localparam sval_t SV_M1 = 2'b11;

  typedef enum logic [1:0] {
    TRK_EARLY  = 2'b00,
    TRK_LATE   = 2'b01,
    TRK_DITHER = 2'b10,
    TRK_EML    = 2'b11
  } trk_sel_e;

  // chip 0 -> +1, chip 1 -> -1; forced +1 in code-off test
  function automatic sval_t chip_to_sval(input logic chip, input logic off);
    if (off) return SV_P1;
    return chip ? SV_M1 : SV_P1;
  endfunction
endpackage

// File: rtl/trk_dither_seq.sv
module trk_dither_seq #(
  parameter int unsigned PERIODS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic epoch_i,
  output logic late_phase_o
);
  localparam int unsigned CW = (PERIODS > 1) ? $clog2(PERIODS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIODS - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          wrap;

  assign wrap = epoch_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (epoch_i) begin
      if (wrap) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign late_phase_o = phase_q;

  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_phase_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epoch_i && cnt_q == LAST) |=> (phase_q != $past(phase_q)) && (cnt_q == '0));
  p_phase_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_i |=> $stable(phase_q) && $stable(cnt_q));
endmodule

// File: rtl/trk_arm_mux.sv
module trk_arm_mux
  import trk_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       early_i,
  input  logic       late_i,
  input  logic       off_i,
  input  logic       late_phase_i,
  output sval_t      val_o
);
  trk_sel_e sel;
  logic     pick;

  assign sel = trk_sel_e'(sel_i);

  always_comb begin
    pick = early_i;
    val_o = SV_Z;
    unique case (sel)
      TRK_EARLY:  pick = early_i;
      TRK_LATE:   pick = late_i;
      TRK_DITHER: pick = late_phase_i ? late_i : early_i;
      default:    pick = early_i;
    endcase
    if (sel == TRK_EML) begin
      // halved difference: 0 when equal, else sign of early
      if (off_i || (early_i == late_i)) val_o = SV_Z;
      else                              val_o = chip_to_sval(early_i, 1'b0);
    end else begin
      val_o = chip_to_sval(pick, off_i);
    end
  end
endmodule

// File: rtl/trk_code_sel.sv
module trk_code_sel
  import trk_pkg::*;
#(
  parameter int unsigned DITHER_LEN = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       early_i,
  input  logic       prompt_i,
  input  logic       late_i,
  input  logic [1:0] trk_sel_i,
  input  logic       code_off_i,
  input  logic       epoch_i,
  output logic [1:0] prompt_o,
  output logic [1:0] early_o,
  output logic [1:0] late_o,
  output logic [1:0] track_o,
  output logic       dither_late_o
);
  localparam int unsigned NCH = 3;

  logic [NCH-1:0] chips;
  sval_t          mapped [NCH];
  sval_t          mapped_q [NCH];
  sval_t          trk_d, trk_q;
  logic           late_phase;

  assign chips = {early_i, prompt_i, late_i};

  for (genvar g = 0; g < NCH; g++) begin : g_chip
    assign mapped[g] = chip_to_sval(chips[g], code_off_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mapped_q[g] <= SV_Z;
      else         mapped_q[g] <= mapped[g];
    end
  end

  trk_dither_seq #(.PERIODS(DITHER_LEN)) u_dither (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .epoch_i      (epoch_i),
    .late_phase_o (late_phase)
  );

  trk_arm_mux u_arm (
    .sel_i        (trk_sel_i),
    .early_i      (early_i),
    .late_i       (late_i),
    .off_i        (code_off_i),
    .late_phase_i (late_phase),
    .val_o        (trk_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trk_q <= SV_Z;
    else         trk_q <= trk_d;
  end

  assign late_o        = mapped_q[0];
  assign prompt_o      = mapped_q[1];
  assign early_o       = mapped_q[2];
  assign track_o       = trk_q;
  assign dither_late_o = late_phase;

  p_prompt_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_off_i |=> prompt_o == ($past(prompt_i) ? 2'b11 : 2'b01));
  p_code_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_off_i |=> (prompt_o == 2'b01) && (early_o == 2'b01) && (late_o == 2'b01));
  p_eml_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_sel_i == 2'b11 && !code_off_i) |=>
      track_o == (($past(early_i) == $past(late_i)) ? 2'b00 :
                  ($past(early_i) ? 2'b11 : 2'b01)));
  p_off_trk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_off_i |=> track_o == (($past(trk_sel_i) == 2'b11) ? 2'b00 : 2'b01));
  p_dither_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_sel_i == 2'b10 && !code_off_i) |=>
      track_o == (($past(late_phase) ? $past(late_i) : $past(early_i)) ? 2'b11 : 2'b01));
  p_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    track_o != 2'b10);
  p_nonzero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_sel_i != 2'b11) |=> track_o != 2'b00);
endmodule

// File: tb/sim_trk_code_sel.sv
`timescale 1ns/1ps
module sim_trk_code_sel;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       early_i = 1'b0, prompt_i = 1'b0, late_i = 1'b0;
  logic [1:0] trk_sel_i = 2'b00;
  logic       code_off_i = 1'b0;
  logic       epoch_i = 1'b0;
  logic [1:0] prompt_o, early_o, late_o, track_o;
  logic       dither_late_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] P1 = 2'b01, Z = 2'b00, M1 = 2'b11;

  // {off, sel[1:0], e, p, l, exp_p, exp_e, exp_l, exp_t}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 2'b00, 3'b000, 8'b01_01_01_01},
    {1'b0, 2'b00, 3'b100, 8'b01_11_01_11},
    {1'b0, 2'b01, 3'b100, 8'b01_11_01_01},
    {1'b0, 2'b01, 3'b011, 8'b11_01_11_11},
    {1'b0, 2'b11, 3'b001, 8'b01_01_11_01},
    {1'b0, 2'b11, 3'b110, 8'b11_11_01_11},
    {1'b0, 2'b11, 3'b101, 8'b01_11_11_00},
    {1'b0, 2'b11, 3'b010, 8'b11_01_01_00},
    {1'b0, 2'b10, 3'b100, 8'b01_11_01_11},
    {1'b0, 2'b10, 3'b011, 8'b11_01_11_01},
    {1'b1, 2'b00, 3'b111, 8'b01_01_01_01},
    {1'b1, 2'b01, 3'b101, 8'b01_01_01_01},
    {1'b1, 2'b11, 3'b100, 8'b01_01_01_00},
    {1'b1, 2'b10, 3'b011, 8'b01_01_01_01}
  };

  trk_code_sel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .early_i(early_i), .prompt_i(prompt_i),
    .late_i(late_i), .trk_sel_i(trk_sel_i), .code_off_i(code_off_i),
    .epoch_i(epoch_i), .prompt_o(prompt_o), .early_o(early_o),
    .late_o(late_o), .track_o(track_o), .dither_late_o(dither_late_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe();
    epoch_i = 1'b1;
    tick();
    epoch_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    // R9 reset state
    early_i = 1'b1; prompt_i = 1'b1; late_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 prompt", prompt_o, Z);
    chk("R9 early", early_o, Z);
    chk("R9 late", late_o, Z);
    chk("R9 track", track_o, Z);
    chk("R9 phase", {1'b0, dither_late_o}, 2'b00);
    rst_ni = 1'b1;

    // table: no strobes, dither stays in early half
    for (int i = 0; i < NV; i++) begin
      code_off_i = VEC[i][13];
      trk_sel_i  = VEC[i][12:11];
      early_i    = VEC[i][10];
      prompt_i   = VEC[i][9];
      late_i     = VEC[i][8];
      tick();
      if (VEC[i][13])              tag = "R2 R6";
      else if (VEC[i][12:11] == 3) tag = "R5";
      else if (VEC[i][12:11] == 2) tag = "R7";
      else if (VEC[i][12:11] == 1) tag = "R4";
      else                         tag = "R3";
      chk({"R1 ", tag, " prompt"}, prompt_o, VEC[i][7:6]);
      chk({"R1 ", tag, " early"}, early_o, VEC[i][5:4]);
      chk({"R1 ", tag, " late"}, late_o, VEC[i][3:2]);
      chk({tag, " R11 track"}, track_o, VEC[i][1:0]);
    end

    // R12: change between edges is not visible until the next edge
    code_off_i = 1'b0; trk_sel_i = 2'b00; early_i = 1'b0; late_i = 1'b1;
    tick();
    chk("R12 settled", track_o, P1);
    early_i = 1'b1;
    #2;
    chk("R12 before edge", track_o, P1);
    tick();
    chk("R12 after edge", track_o, M1);

    // R8 / R7 dither run
    trk_sel_i = 2'b10; early_i = 1'b0; late_i = 1'b1;
    repeat (19) strobe();
    chk("R8 phase after 19", {1'b0, dither_late_o}, 2'b00);
    tick();
    chk("R7 early half", track_o, P1);
    strobe();
    chk("R8 phase after 20", {1'b0, dither_late_o}, 2'b01);
    tick();
    chk("R7 late half", track_o, M1);

    // R10: select change mid-run keeps the count
    trk_sel_i = 2'b00;
    tick();
    chk("R3 early in late half", track_o, P1);
    repeat (10) strobe();
    trk_sel_i = 2'b10;
    repeat (9) strobe();
    chk("R10 phase after 19", {1'b0, dither_late_o}, 2'b01);
    strobe();
    chk("R10 phase after 20", {1'b0, dither_late_o}, 2'b00);
    tick();
    chk("R7 back to early", track_o, P1);

    // R6 code-off in dither late half still gives +1
    repeat (20) strobe();
    code_off_i = 1'b1;
    tick();
    chk("R6 off dither", track_o, P1);
    chk("R8 phase late again", {1'b0, dither_late_o}, 2'b01);

    finish_run();
  end
endmodule